// File: doc/BRIEF.md
# Asymmetric Lamp Flash Timer

This block produces the blink phase that is shared by the turn indicators and the hazard flashers. A lamp controller feeds it an `active` level, which is the OR of the left, right and hazard requests. It also feeds a single-cycle `tick` enable from a slow time base. The block returns a phase mask. The lit and dark intervals have different lengths: the defaults are 2 and 1 units, which gives a two-thirds duty cycle.

While `active` is low the timer parks in a known state: the phase is dark and the interval counter is preloaded with the lit length. When `active` rises, the phase turns lit on the next clock edge. Every flash sequence therefore opens with a lit interval of full length, whatever happened before. The mask is all ones while dark, so the controller can OR it directly onto active-low lamp drives.

Top module: `lamp_flash_timer`

## Requirements
- R1: During reset and after it, while `active` stays low, `dark_mask` is all ones.
- R2: In any cycle whose `active` is low, `dark_mask` is all ones after the next clock edge, whatever `tick` does.
- R3: On the clock edge where `active` is high and was low in the previous cycle (or where the first active cycle follows reset), `dark_mask` becomes all zeros (lit). A `tick` present in that same cycle is not counted.
- R4: After a start, the lit phase lasts exactly `LIT_TICKS` counted ticks. The edge that takes the `LIT_TICKS`-th tick switches `dark_mask` to all ones.
- R5: The dark phase lasts exactly `DARK_TICKS` counted ticks. The edge that takes the `DARK_TICKS`-th tick switches back to lit, and the cycle then repeats indefinitely.
- R6: While `active` stays high, a cycle with `tick` low leaves `dark_mask` unchanged across the next edge.
- R7: When `active` drops part way through an interval and later rises again, the new sequence starts with a full lit interval. No part of the earlier count carries over.
- R8: All bits of `dark_mask` are always equal: all ones means dark, all zeros means lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| tick | input | 1 | Single-cycle time-base enable |
| active | input | 1 | High while any flasher (left, right or hazard) is requested |
| dark_mask | output | MASK_W | All ones while dark, all zeros while lit |

## Verification
The hardest situation to reach from the ports is a restart that lands in the middle of an interval, with a partly spent counter left over from the previous sequence. The bench sweeps the point at which `active` drops, from the first tick to beyond two full periods. At each drop point it raises `active` again and checks that a full lit interval follows. The tick spacing is also swept, and a tick is placed on the start cycle itself, so that the uncounted start edge is exercised together with ordinary ones. A pseudo-random stretch mixes irregular ticks with short idle gaps.

// File: rtl/flash_timer_pkg.sv
package flash_timer_pkg;

  typedef enum logic {
    PH_LIT  = 1'b0,
    PH_DARK = 1'b1
  } phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/flash_down_counter.sv
module flash_down_counter #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_phase_flag.sv
module flash_phase_flag
  import flash_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   force_dark,
  input  logic   start_lit,
  input  logic   flip,
  output phase_e phase
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (force_dark) begin
      phase_d = PH_DARK;
    end else if (start_lit) begin
      phase_d = PH_LIT;
    end else if (flip) begin
      phase_d = (phase_q == PH_DARK) ? PH_LIT : PH_DARK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DARK;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/lamp_flash_timer.sv
module lamp_flash_timer
  import flash_timer_pkg::*;
#(
  parameter int unsigned LIT_TICKS  = 32,
  parameter int unsigned DARK_TICKS = 16,
  parameter int unsigned MASK_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  output logic [MASK_W-1:0] dark_mask
);

  localparam int unsigned MAX_TICKS = max_u(LIT_TICKS, DARK_TICKS);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] LIT_VAL  = CNT_W'(LIT_TICKS);
  localparam logic [CNT_W-1:0] DARK_VAL = CNT_W'(DARK_TICKS);

  logic             rst_int_n;
  logic             run_q;
  logic             run_d;
  logic             start;
  logic             counting;
  logic             at_last;
  logic             expire;
  logic             load;
  logic [CNT_W-1:0] load_val;
  phase_e           phase;

  flash_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // sequence-start detection: first active cycle after idle
  always_comb begin
    start    = active && !run_q;
    counting = active && run_q && tick;
    expire   = counting && at_last;
    run_d    = active;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  // reload selection: the idle and start cases preload the lit length; on
  // expiry the length matching the phase about to be entered is loaded
  always_comb begin
    load = !active || start || expire;
    if (!active || start || (phase == PH_DARK)) begin
      load_val = LIT_VAL;
    end else begin
      load_val = DARK_VAL;
    end
  end

  flash_down_counter #(
    .CNT_W   (CNT_W),
    .RST_VAL (LIT_TICKS)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .load_val (load_val),
    .dec      (counting),
    .at_last  (at_last)
  );

  flash_phase_flag u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .force_dark (!active),
    .start_lit  (start),
    .flip       (expire),
    .phase      (phase)
  );

  for (genvar b = 0; b < MASK_W; b++) begin : g_mask
    assign dark_mask[b] = (phase == PH_DARK);
  end

endmodule

// File: rtl/lamp_flash_timer_chk.sv
module lamp_flash_timer_chk #(
  parameter int unsigned MASK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              active,
  input logic [MASK_W-1:0] dark_mask
);

  // R8
  mask_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_mask == '0) || (dark_mask == '1));

  // R2
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (dark_mask == '1));

  // R3
  start_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |=> (dark_mask == '0));

  // R6
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(rst_n) && !tick) |=> $stable(dark_mask));

endmodule

bind lamp_flash_timer lamp_flash_timer_chk #(
  .MASK_W (MASK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .tick      (tick),
  .active    (active),
  .dark_mask (dark_mask)
);

// File: tb/lamp_flash_timer_test.sv
`timescale 1ns/1ps
module lamp_flash_timer_test;

  localparam int unsigned L = 4;
  localparam int unsigned D = 2;
  localparam int unsigned W = 4;

  logic         clk;
  logic         rst_n;
  logic         tick;
  logic         active;
  logic [W-1:0] dark_mask;

  int checks;
  int failures;
  int started;
  int k;

  lamp_flash_timer #(
    .LIT_TICKS  (L),
    .DARK_TICKS (D),
    .MASK_W     (W)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .active    (active),
    .dark_mask (dark_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: dark_mask=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive at negedge, model the edge, sample at next negedge
  task automatic cyc(input logic a, input logic t, input string ovr);
    string tag;
    logic [W-1:0] exp;
    active = a;
    tick   = t;
    @(posedge clk);
    if (!a) begin
      started = 0; k = 0; tag = "R2";
    end else if (started == 0) begin
      started = 1; k = 0; tag = "R3";
    end else begin
      if (t) k++;
      tag = "R6";
    end
    if (started == 0) exp = '1;
    else exp = ((k % (L + D)) < L) ? '0 : '1;
    if (a && started != 0 && t && tag == "R6") tag = (exp == '0) ? "R4" : "R5";
    if (ovr != "") tag = ovr;
    @(negedge clk);
    check(tag, dark_mask, exp);
    checks++;
    if (!(dark_mask == '0 || dark_mask == '1)) begin
      failures++;
      $display("FAIL R8: dark_mask=%b expected uniform", dark_mask);
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    checks = 0; failures = 0; started = 0; k = 0;
    rst_n = 1'b0; active = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", dark_mask, '1);
    active = 1'b1; tick = 1'b1;
    @(negedge clk);
    check("R1", dark_mask, '1);
    active = 1'b0; tick = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, "R1");

    // idle with ticks: stays dark
    for (int i = 0; i < 20; i++) cyc(1'b0, i[0], "R2");

    // tick spacing sweep, tick on the start cycle as well
    for (int p = 1; p <= 4; p++) begin
      for (int i = 0; i < 3 * (L + D) * p + 5; i++) cyc(1'b1, (i % p) == 0, "");
      for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, "R2");
    end

    // restart from every drop point
    for (int dp = 0; dp <= 2 * (L + D) + 1; dp++) begin
      for (int i = 0; i < dp; i++) cyc(1'b1, 1'b1, "");
      cyc(1'b0, 1'b1, "R7");
      cyc(1'b0, 1'b0, "R7");
      cyc(1'b1, 1'b0, "R7");
      for (int i = 0; i < L + D + 2; i++) cyc(1'b1, 1'b1, (i < L - 1) ? "R7" : "");
      cyc(1'b0, 1'b0, "R2");
    end

    // pseudo-random ticks and short idle gaps
    lf = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      cyc(lf[7:5] != 3'b000, lf[0], "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule